// File: doc/BRIEF.md
# Control Register and Timestamp Access Unit

This unit serves the privileged register-access operations of a processor core. It executes one request per cycle: reading or writing a numbered control register, the machine-status-word load that touches only the bottom four bits of control register 0, reading the timestamp (plain or with an auxiliary word), and attempting a performance-counter read. Control registers 0, 3 and 4 live in dedicated registers. Register 8, the task priority, is routed either to an external priority controller or to a local 4-bit shadow, depending on a virtual-interrupt mode input. Every other register number lands in a small generic store.

The timestamp is a free-running 64-bit counter plus a programmable 64-bit offset. Software-visible offset and auxiliary values are loaded through a side configuration port. Timestamp and counter reads are gated by two control register 4 bits when the caller is not at privilege 0. Every result, including a fault code, is registered and comes back exactly one cycle after the request with a single-cycle valid pulse.

Top module: `crtsc_unit`

## Requirements
- R1: After reset, control registers 0, 3, 4, every generic register, the priority shadow, the offset, the auxiliary word and the counter are all zero, and rsp_valid and tpr_ext_wr are low.
- R2: A request sampled with req_valid high produces rsp_valid high in the following cycle only; with no request, rsp_valid stays low.
- R3: Op 1 (write) to register numbers other than 8 stores the full value; op 0 (read) returns it on rsp_data with fault code 0. Writes to register 0 may clear bit 0 freely.
- R4: Reading register 8 returns the external priority input (zero-extended) when vintr_mode is 0, and the 4-bit shadow when vintr_mode is 1.
- R5: Writing register 8 always stores the value's low 4 bits into the shadow; when vintr_mode is 0 it also pulses tpr_ext_wr one cycle later with tpr_ext_wdata equal to those 4 bits, and when vintr_mode is 1 tpr_ext_wr stays low.
- R6: Op 2 (status-word load) sets control register 0 to (old AND NOT 0xE) OR (value AND 0xF): bits above 3 are kept and bit 0 can be set but never cleared.
- R7: Op 3 (timestamp read) returns counter-plus-offset, where the counter holds the number of clocks since reset at the sampling edge; low 32 bits on rsp_eax, high 32 on rsp_edx, rsp_ecx zero.
- R8: A timestamp read (op 3 or 4) with control register 4 bit 2 set and req_cpl not 0 returns fault code 1 (general protection) with rsp_eax, rsp_edx and rsp_ecx zero.
- R9: Op 4 returns the same pair as op 3 plus the auxiliary word on rsp_ecx.
- R10: Op 5 (counter read) returns fault code 1 when control register 4 bit 8 is set and req_cpl is not 0, and fault code 2 (invalid opcode) otherwise.
- R11: A side-port write with cfg_sel 0 loads the 64-bit offset; with cfg_sel 1 it loads the low 32 bits into the auxiliary word; later timestamp reads reflect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (0 read, 1 write, 2 status-word load, 3 timestamp, 4 timestamp with aux, 5 counter read) |
| req_crn | input | 4 | Control register number |
| req_wdata | input | 32 | Write value |
| req_cpl | input | 2 | Current privilege level |
| vintr_mode | input | 1 | Virtual-interrupt mode |
| tpr_ext_rdata | input | 4 | Priority value from the external controller |
| tpr_ext_wr | output | 1 | Priority forward strobe |
| tpr_ext_wdata | output | 4 | Priority forward value |
| cfg_wr | input | 1 | Side-port write strobe |
| cfg_sel | input | 1 | Side-port target: 0 offset, 1 auxiliary |
| cfg_wdata | input | 64 | Side-port value |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 32 | Control register read data |
| rsp_eax | output | 32 | Timestamp low half |
| rsp_edx | output | 32 | Timestamp high half |
| rsp_ecx | output | 32 | Auxiliary word |
| rsp_fault | output | 2 | 0 none, 1 general protection, 2 invalid opcode |

## Verification
The assertions assume req_op only carries codes 0 to 5 and that requests are not issued while rst is high; the bench draws op codes from that range and holds req_valid low during reset. They also take the side port and requests as independent, and the bench keeps configuration writes in cycles of their own so each timestamp expectation uses a settled offset. Privilege, mode, register number and data are drawn freely, so both gating bits of control register 4 get set and cleared by random writes.

// File: rtl/crtsc_pkg.sv
package crtsc_pkg;
  typedef enum logic [2:0] {
    OP_RD_CR   = 3'd0,
    OP_WR_CR   = 3'd1,
    OP_LOAD_SW = 3'd2,
    OP_RD_TS   = 3'd3,
    OP_RD_TSX  = 3'd4,
    OP_RD_PC   = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_UD   = 2'd2
  } fault_e;

  localparam int TS_GATE_BIT = 2;
  localparam int PC_GATE_BIT = 8;
  localparam int PRIO_CRN    = 8;
endpackage

// File: rtl/crtsc_gate.sv
module crtsc_gate
  import crtsc_pkg::*;
(
  input  logic [2:0] op,
  input  logic [1:0] cpl,
  input  logic       ts_gate,
  input  logic       pc_gate,
  output logic [1:0] fault
);
  logic user_lvl;
  assign user_lvl = (cpl != 2'd0);

  always_comb begin
    fault = FLT_NONE;
    case (op)
      OP_RD_TS, OP_RD_TSX: if (ts_gate && user_lvl) fault = FLT_GP;
      OP_RD_PC:            fault = (pc_gate && user_lvl) ? FLT_GP : FLT_UD;
      default:             fault = FLT_NONE;
    endcase
  end
endmodule

// File: rtl/crtsc_regfile.sv
module crtsc_regfile
  import crtsc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CRN_W = 4,
  parameter int PRI_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             sw_en,
  input  logic [CRN_W-1:0] crn,
  input  logic [XLEN-1:0]  wdata,
  input  logic             vmode,
  input  logic [PRI_W-1:0] pri_ext,
  output logic [XLEN-1:0]  rdata,
  output logic [XLEN-1:0]  cr0,
  output logic [XLEN-1:0]  cr4,
  output logic [PRI_W-1:0] pri_shadow
);
  localparam int NREG = 1 << CRN_W;

  logic [XLEN-1:0] cr3;
  logic [XLEN-1:0] gen_q [NREG];
  logic            dedicated;

  assign dedicated = (crn == CRN_W'(0)) || (crn == CRN_W'(3)) ||
                     (crn == CRN_W'(4)) || (crn == CRN_W'(PRIO_CRN));

  always_ff @(posedge clk) begin
    if (rst) begin
      cr0        <= '0;
      cr3        <= '0;
      cr4        <= '0;
      pri_shadow <= '0;
    end else if (sw_en) begin
      cr0 <= (cr0 & ~XLEN'(32'hE)) | (wdata & XLEN'(32'hF));
    end else if (wr_en) begin
      case (crn)
        CRN_W'(0):        cr0        <= wdata;
        CRN_W'(3):        cr3        <= wdata;
        CRN_W'(4):        cr4        <= wdata;
        CRN_W'(PRIO_CRN): pri_shadow <= wdata[PRI_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_gen
    always_ff @(posedge clk) begin
      if (rst)
        gen_q[g] <= '0;
      else if (wr_en && !dedicated && crn == CRN_W'(g))
        gen_q[g] <= wdata;
    end
  end

  always_comb begin
    case (crn)
      CRN_W'(0):        rdata = cr0;
      CRN_W'(3):        rdata = cr3;
      CRN_W'(4):        rdata = cr4;
      CRN_W'(PRIO_CRN): rdata = XLEN'(vmode ? pri_shadow : pri_ext);
      default:          rdata = gen_q[crn];
    endcase
  end
endmodule

// File: rtl/crtsc_stamp.sv
module crtsc_stamp #(
  parameter int TS_W  = 64,
  parameter int AUX_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [TS_W-1:0]  cfg_wdata,
  output logic [TS_W-1:0]  stamp,
  output logic [AUX_W-1:0] aux
);
  logic [TS_W-1:0] cnt_q;
  logic [TS_W-1:0] ofs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ofs_q <= '0;
      aux   <= '0;
    end else begin
      cnt_q <= cnt_q + TS_W'(1);
      if (cfg_wr && !cfg_sel) ofs_q <= cfg_wdata;
      if (cfg_wr &&  cfg_sel) aux   <= cfg_wdata[AUX_W-1:0];
    end
  end

  assign stamp = cnt_q + ofs_q;
endmodule

// File: rtl/crtsc_unit.sv
module crtsc_unit
  import crtsc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CRN_W = 4,
  parameter int PRI_W = 4,
  parameter int TS_W  = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [CRN_W-1:0] req_crn,
  input  logic [XLEN-1:0]  req_wdata,
  input  logic [1:0]       req_cpl,
  input  logic             vintr_mode,
  input  logic [PRI_W-1:0] tpr_ext_rdata,
  output logic             tpr_ext_wr,
  output logic [PRI_W-1:0] tpr_ext_wdata,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [TS_W-1:0]  cfg_wdata,
  output logic             rsp_valid,
  output logic [XLEN-1:0]  rsp_data,
  output logic [TS_W/2-1:0] rsp_eax,
  output logic [TS_W/2-1:0] rsp_edx,
  output logic [TS_W/2-1:0] rsp_ecx,
  output logic [1:0]       rsp_fault
);
  localparam int HALF = TS_W / 2;

  logic [XLEN-1:0]  crf_rdata;
  logic [XLEN-1:0]  cr0_w;
  logic [XLEN-1:0]  cr4_w;
  logic [PRI_W-1:0] shadow_w;
  logic [TS_W-1:0]  stamp_w;
  logic [HALF-1:0]  aux_w;
  logic [1:0]       fault_w;
  logic             wr_go, sw_go, fwd_go;

  assign wr_go  = req_valid && (req_op == OP_WR_CR);
  assign sw_go  = req_valid && (req_op == OP_LOAD_SW);
  assign fwd_go = wr_go && (req_crn == CRN_W'(PRIO_CRN)) && !vintr_mode;

  crtsc_regfile #(.XLEN(XLEN), .CRN_W(CRN_W), .PRI_W(PRI_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_go), .sw_en(sw_go), .crn(req_crn),
    .wdata(req_wdata), .vmode(vintr_mode), .pri_ext(tpr_ext_rdata),
    .rdata(crf_rdata), .cr0(cr0_w), .cr4(cr4_w), .pri_shadow(shadow_w)
  );

  crtsc_stamp #(.TS_W(TS_W), .AUX_W(HALF)) u_stamp (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .stamp(stamp_w), .aux(aux_w)
  );

  crtsc_gate u_gate (
    .op(req_op), .cpl(req_cpl), .ts_gate(cr4_w[TS_GATE_BIT]),
    .pc_gate(cr4_w[PC_GATE_BIT]), .fault(fault_w)
  );

  logic [XLEN-1:0] nx_data;
  logic [HALF-1:0] nx_eax, nx_edx, nx_ecx;

  always_comb begin
    nx_data = '0;
    nx_eax  = '0;
    nx_edx  = '0;
    nx_ecx  = '0;
    if (fault_w == FLT_NONE) begin
      case (req_op)
        OP_RD_CR: nx_data = crf_rdata;
        OP_RD_TS: begin
          nx_eax = stamp_w[HALF-1:0];
          nx_edx = stamp_w[TS_W-1:HALF];
        end
        OP_RD_TSX: begin
          nx_eax = stamp_w[HALF-1:0];
          nx_edx = stamp_w[TS_W-1:HALF];
          nx_ecx = aux_w;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_data      <= '0;
      rsp_eax       <= '0;
      rsp_edx       <= '0;
      rsp_ecx       <= '0;
      rsp_fault     <= FLT_NONE;
      tpr_ext_wr    <= 1'b0;
      tpr_ext_wdata <= '0;
    end else begin
      rsp_valid  <= req_valid;
      tpr_ext_wr <= fwd_go;
      if (fwd_go) tpr_ext_wdata <= req_wdata[PRI_W-1:0];
      if (req_valid) begin
        rsp_data  <= nx_data;
        rsp_eax   <= nx_eax;
        rsp_edx   <= nx_edx;
        rsp_ecx   <= nx_ecx;
        rsp_fault <= fault_w;
      end
    end
  end
endmodule

// File: rtl/crtsc_unit_chk.sv
module crtsc_unit_chk
  import crtsc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CRN_W = 4,
  parameter int PRI_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [2:0]       req_op,
  input logic [CRN_W-1:0] req_crn,
  input logic [PRI_W-1:0] wlow,
  input logic [1:0]       req_cpl,
  input logic             vintr_mode,
  input logic             rsp_valid,
  input logic [1:0]       rsp_fault,
  input logic             tpr_ext_wr,
  input logic             pe_bit,
  input logic             ts_gate,
  input logic [PRI_W-1:0] shadow
);
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid)); // R2

  AST_PE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_LOAD_SW && pe_bit) |=> pe_bit); // R6

  AST_TS_GATED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_op == OP_RD_TS || req_op == OP_RD_TSX) && ts_gate && req_cpl != 2'd0)
    |=> (rsp_fault == FLT_GP)); // R8

  AST_PC_FAULTS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_RD_PC) |=> (rsp_fault != FLT_NONE)); // R10

  AST_PRI_FWD: assert property (@(posedge clk) disable iff (rst)
    tpr_ext_wr |-> $past(req_valid && req_op == OP_WR_CR &&
                         req_crn == CRN_W'(PRIO_CRN) && !vintr_mode)); // R5

  AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_WR_CR && req_crn == CRN_W'(PRIO_CRN))
    |=> (shadow == $past(wlow))); // R5
endmodule

bind crtsc_unit crtsc_unit_chk #(.XLEN(XLEN), .CRN_W(CRN_W), .PRI_W(PRI_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_crn(req_crn),
  .wlow(req_wdata[PRI_W-1:0]), .req_cpl(req_cpl), .vintr_mode(vintr_mode),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .tpr_ext_wr(tpr_ext_wr),
  .pe_bit(cr0_w[0]), .ts_gate(cr4_w[crtsc_pkg::TS_GATE_BIT]), .shadow(shadow_w)
);

// File: tb/crtsc_unit_tb_top.sv
module crtsc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [3:0]  req_crn = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_cpl = '0;
  logic        vintr_mode = 1'b0;
  logic [3:0]  tpr_ext_rdata = '0;
  logic        tpr_ext_wr;
  logic [3:0]  tpr_ext_wdata;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [63:0] cfg_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data, rsp_eax, rsp_edx, rsp_ecx;
  logic [1:0]  rsp_fault;

  always #10 clk = ~clk;

  crtsc_unit dut_i (.*);

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] cyc_m;
  logic [31:0] cr_m [16];
  logic [3:0]  sh_m;
  logic [63:0] ofs_m;
  logic [31:0] aux_m;

  always @(posedge clk) cyc_m <= rst ? 64'd0 : cyc_m + 64'd1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_fault(input logic [2:0] op, input logic [1:0] cpl);
    if ((op == 3'd3 || op == 3'd4) && cr_m[4][2] && cpl != 0) return 2'd1;
    if (op == 3'd5) return (cr_m[4][8] && cpl != 0) ? 2'd1 : 2'd2;
    return 2'd0;
  endfunction

  task automatic do_op(input logic [2:0] op, input logic [3:0] crn, input logic [31:0] wd,
                       input logic [1:0] cpl, input logic vm, input logic [3:0] ext);
    logic [1:0]  ef;
    logic [31:0] ed, ea, ex, ec;
    logic [63:0] st;
    logic        efw;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_crn = crn; req_wdata = wd;
    req_cpl = cpl; vintr_mode = vm; tpr_ext_rdata = ext;
    ef = exp_fault(op, cpl);
    st = cyc_m + ofs_m;
    ed = '0; ea = '0; ex = '0; ec = '0;
    efw = 1'b0;
    if (ef == 2'd0) begin
      if (op == 3'd0) ed = (crn == 4'd8) ? (vm ? {28'd0, sh_m} : {28'd0, ext}) : cr_m[crn];
      if (op == 3'd3 || op == 3'd4) begin ea = st[31:0]; ex = st[63:32]; end
      if (op == 3'd4) ec = aux_m;
    end
    if (op == 3'd1) begin
      if (crn == 4'd8) begin sh_m = wd[3:0]; efw = !vm; end
      else cr_m[crn] = wd;
    end
    if (op == 3'd2) cr_m[0] = (cr_m[0] & ~32'hE) | (wd & 32'hF);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R2 valid", 64'(rsp_valid), 64'd1);
    chk(rsp_fault === ef, (op == 3'd5) ? "R10 fault" : "R8 fault", 64'(rsp_fault), 64'(ef));
    chk(rsp_data === ed, (crn == 4'd8) ? "R4 data" : "R3 data", 64'(rsp_data), 64'(ed));
    chk(rsp_eax === ea, "R7 eax", 64'(rsp_eax), 64'(ea));
    chk(rsp_edx === ex, "R7 edx", 64'(rsp_edx), 64'(ex));
    chk(rsp_ecx === ec, "R9 ecx", 64'(rsp_ecx), 64'(ec));
    chk(tpr_ext_wr === efw, "R5 fwd strobe", 64'(tpr_ext_wr), 64'(efw));
    if (efw) chk(tpr_ext_wdata === wd[3:0], "R5 fwd data", 64'(tpr_ext_wdata), 64'(wd[3:0]));
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R2 pulse", 64'(rsp_valid), 64'd0);
    chk(tpr_ext_wr === 1'b0, "R5 strobe pulse", 64'(tpr_ext_wr), 64'd0);
  endtask

  task automatic cfg(input logic sel, input logic [63:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = v;
    if (sel) aux_m = v[31:0]; else ofs_m = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", n_chk, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) cr_m[i] = '0;
    sh_m = '0; ofs_m = '0; aux_m = '0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: reset state
    chk(rsp_valid === 1'b0, "R1 valid", 64'(rsp_valid), 64'd0);
    chk(tpr_ext_wr === 1'b0, "R1 strobe", 64'(tpr_ext_wr), 64'd0);
    do_op(3'd0, 4'd0, 0, 0, 0, 0);
    do_op(3'd0, 4'd3, 0, 0, 0, 0);
    do_op(3'd0, 4'd4, 0, 0, 0, 0);
    do_op(3'd0, 4'd9, 0, 0, 0, 0);
    do_op(3'd0, 4'd8, 0, 0, 1, 4'hA);   // R1 shadow zero, R4 shadow path
    do_op(3'd4, 4'd0, 0, 0, 0, 0);      // R1 counter/offset/aux zero
    // R4/R5 directed
    do_op(3'd1, 4'd8, 32'hFFFF_FFF6, 0, 0, 0);
    do_op(3'd0, 4'd8, 0, 0, 1, 4'h3);
    do_op(3'd0, 4'd8, 0, 0, 0, 4'h3);
    do_op(3'd1, 4'd8, 32'h9, 0, 1, 0);
    do_op(3'd0, 4'd8, 0, 0, 1, 4'h0);
    // R6 directed: bit0 sticky, upper bits kept
    do_op(3'd1, 4'd0, 32'h8000_0011, 0, 0, 0);
    do_op(3'd2, 4'd0, 32'hFFFF_FFF0, 0, 0, 0);
    do_op(3'd0, 4'd0, 0, 0, 0, 0);
    do_op(3'd2, 4'd0, 32'h0000_000E, 0, 0, 0);
    do_op(3'd0, 4'd0, 0, 0, 0, 0);
    do_op(3'd1, 4'd0, 32'h0, 0, 0, 0);   // R3 plain write clears bit 0
    do_op(3'd0, 4'd0, 0, 0, 0, 0);
    // R11 side port, R7/R9
    cfg(1'b0, 64'h0000_0001_FFFF_FFF0);
    cfg(1'b1, 64'hDEAD_0000_1234_5678);
    do_op(3'd3, 4'd0, 0, 3, 0, 0);
    do_op(3'd4, 4'd0, 0, 3, 0, 0);
    // R8/R10 directed
    do_op(3'd1, 4'd4, 32'h0000_0104, 0, 0, 0);
    do_op(3'd3, 4'd0, 0, 1, 0, 0);
    do_op(3'd4, 4'd0, 0, 0, 0, 0);
    do_op(3'd5, 4'd0, 0, 2, 0, 0);
    do_op(3'd5, 4'd0, 0, 0, 0, 0);
    do_op(3'd1, 4'd4, 32'h0, 0, 0, 0);
    do_op(3'd4, 4'd0, 0, 3, 0, 0);
    do_op(3'd5, 4'd0, 0, 3, 0, 0);
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [2:0]  op;
      logic [31:0] wd;
      op = 3'($urandom_range(5));
      wd = $urandom;
      if (op == 3'd1 && ($urandom_range(3) == 0)) wd[8] = wd[2];
      if (($urandom_range(15)) == 0) cfg(1'($urandom_range(1)), {$urandom, $urandom});
      do_op(op, 4'($urandom_range(15)), wd, 2'($urandom_range(3)),
            1'($urandom_range(1)), 4'($urandom_range(15)));
    end
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule